// File: doc/BRIEF.md
# Tamper-Triggered Security Lock Controller

This block guards the secret state of a secure loader. It holds a lock bit, a key register read by the address and data scramblers, and a small byte store of protected vectors. A loader sets the lock with a command once an image is in place. From then on every loader access to external program or data RAM is refused. The only way back to an open state is to clear the lock, and a clear always costs the secret.

A lock-clear command, or a filtered pulse on the active-high tamper pin, starts a wipe cascade. It cannot be stopped once started. At the edge where the trigger is seen, the key and every vector byte become zero. Next, an address counter walks the external RAM region and writes a zero to each location, one write per acknowledge. Last, a fresh word from the random source is loaded as the new key. A tamper trigger also drops the external memory supply enable for a short window before the RAM walk begins. A busy flag covers the whole cascade.

Top module: `seclock_ctrl`

## Requirements
- R1: After reset the lock is clear, busy is low, the key is zero, `mem_pwr_en` is high and `ram_wr_req` is low.
- R2: The tamper pin passes through a two-flop synchronizer and a run counter. A high run of fewer than REJECT_CYC cycles is ignored. A run of ACCEPT_CYC cycles or more triggers the cascade. The trip point is (REJECT_CYC+ACCEPT_CYC)/2 cycles, and each run triggers at most once.
- R3: A lock-clear command seen while idle clears the lock, zeroes the key and all VEC_BYTES vector bytes, and raises busy, all at the same clock edge. Clear is accepted whether or not the lock is set.
- R4: A tamper trigger while idle has the effect given in R3. In addition, `mem_pwr_en` is low for exactly PWR_OFF_CYC cycles before the first RAM write request.
- R5: The RAM walk raises `ram_wr_req` with `ram_wdata` zero. Addresses start at 0 and rise by one. The address holds while `ram_wr_ack` is low and advances only on an acknowledged cycle. Exactly RAM_DEPTH writes are made.
- R6: On the clock edge after the last acknowledge, the key is loaded from `rng_word` and busy falls.
- R7: While busy, the key reads zero. Set commands, clear commands and tamper pulses have no effect, and the cascade runs to its end.
- R8: The lock is set only by `cmd_lock_set` while idle. If set and clear arrive in the same cycle, clear wins.
- R9: While the lock is set or busy is high, `ld_req` is answered with `ld_deny`=1 and `ld_ok`=0. Otherwise it is answered with `ld_ok`=1 and `ld_deny`=0.
- R10: A vector byte write is taken only while the lock is clear, busy is low and the address is below VEC_BYTES. Reading an address of VEC_BYTES or more returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_lock_set | input | 1 | Strobe: set the lock |
| cmd_lock_clr | input | 1 | Strobe: clear the lock and start the wipe |
| tamper_pin | input | 1 | Raw active-high tamper input, asynchronous |
| rng_word | input | KEY_W | Random word, taken as the new key |
| ld_req | input | 1 | Loader asks for external RAM access |
| ld_ok | output | 1 | Access granted |
| ld_deny | output | 1 | Access refused |
| vec_we | input | 1 | Vector byte write strobe |
| vec_waddr | input | VEC_AW | Vector write address |
| vec_wdata | input | 8 | Vector write data |
| vec_raddr | input | VEC_AW | Vector read address |
| vec_rdata | output | 8 | Vector read data |
| ram_wr_req | output | 1 | Wipe write request to external RAM |
| ram_addr | output | RAM_AW | Wipe write address |
| ram_wdata | output | 8 | Wipe write data (zero) |
| ram_wr_ack | input | 1 | External RAM accepted the write |
| mem_pwr_en | output | 1 | External memory supply enable |
| lock_o | output | 1 | Lock state |
| busy_o | output | 1 | Wipe cascade in progress |
| key_o | output | KEY_W | Current key |

## Verification
Vector bytes are written and read back across a table that includes the last valid index, out-of-range indices and overwrites, so that address decoding is separated from data storage. The wipe is tried under two triggers, a command and a long tamper run. The acknowledge is stalled one cycle on every address, which separates an address that waits for its acknowledge from one that advances freely. Set and clear commands injected in mid-walk show whether the cascade can be disturbed. A tamper run shorter than the reject width must leave a set lock untouched, and the power-off window is counted so that a tamper start can be told from a command start.

// File: rtl/seclock_pkg.sv
package seclock_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_PWROFF = 2'd1,
    SQ_WIPE   = 2'd2,
    SQ_RELOAD = 2'd3
  } seq_state_e;

  // Run length at which a tamper pulse counts as real: midway in the band.
  function automatic int unsigned trip_point(int unsigned rej, int unsigned acc);
    return (rej + acc) / 2;
  endfunction

  // Bits needed to hold values 0..n.
  function automatic int unsigned count_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/tamper_filter.sv
module tamper_filter
  import seclock_pkg::*;
#(
  parameter int unsigned REJECT_CYC = 500,
  parameter int unsigned ACCEPT_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic hit
);
  localparam int unsigned TRIP = trip_point(REJECT_CYC, ACCEPT_CYC);
  localparam int unsigned CW   = count_bits(TRIP);
  localparam logic [CW-1:0] TRIP_V = CW'(TRIP);
  localparam logic [CW-1:0] LAST_V = CW'(TRIP - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_raw};
      if (!sync_q[1])
        run_q <= '0;
      else if (run_q != TRIP_V)
        run_q <= run_q + 1'b1;
    end
  end

  assign hit = sync_q[1] && (run_q == LAST_V);

endmodule

// File: rtl/wipe_seq.sv
module wipe_seq
  import seclock_pkg::*;
#(
  parameter int unsigned RAM_DEPTH   = 32768,
  parameter int unsigned PWR_OFF_CYC = 64,
  parameter int unsigned RAM_AW      = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic              kick_tamper,
  input  logic              ram_wr_ack,
  output logic              busy,
  output logic              mem_pwr_en,
  output logic              ram_wr_req,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              reload
);
  localparam int unsigned PW = count_bits(PWR_OFF_CYC);
  localparam logic [PW-1:0]     POFF_LAST = PW'(PWR_OFF_CYC - 1);
  localparam logic [RAM_AW-1:0] ADDR_LAST = RAM_AW'(RAM_DEPTH - 1);

  seq_state_e        state_q;
  logic [RAM_AW-1:0] addr_q;
  logic [PW-1:0]     pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (kick) begin
          state_q <= kick_tamper ? SQ_PWROFF : SQ_WIPE;
          addr_q  <= '0;
          pcnt_q  <= '0;
        end
        SQ_PWROFF: begin
          if (pcnt_q == POFF_LAST) state_q <= SQ_WIPE;
          else                     pcnt_q  <= pcnt_q + 1'b1;
        end
        SQ_WIPE: if (ram_wr_ack) begin
          if (addr_q == ADDR_LAST) state_q <= SQ_RELOAD;
          else                     addr_q  <= addr_q + 1'b1;
        end
        SQ_RELOAD: state_q <= SQ_IDLE;
        default:   state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != SQ_IDLE);
  assign mem_pwr_en = (state_q != SQ_PWROFF);
  assign ram_wr_req = (state_q == SQ_WIPE);
  assign ram_addr   = addr_q;
  assign reload     = (state_q == SQ_RELOAD);

endmodule

// File: rtl/seclock_ctrl.sv
module seclock_ctrl
  import seclock_pkg::*;
#(
  parameter int unsigned KEY_W       = 64,
  parameter int unsigned VEC_BYTES   = 48,
  parameter int unsigned RAM_DEPTH   = 32768,
  parameter int unsigned REJECT_CYC  = 500,
  parameter int unsigned ACCEPT_CYC  = 2500,
  parameter int unsigned PWR_OFF_CYC = 64,
  parameter int unsigned VEC_AW      = $clog2(VEC_BYTES),
  parameter int unsigned RAM_AW      = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_lock_set,
  input  logic              cmd_lock_clr,
  input  logic              tamper_pin,
  input  logic [KEY_W-1:0]  rng_word,
  input  logic              ld_req,
  output logic              ld_ok,
  output logic              ld_deny,
  input  logic              vec_we,
  input  logic [VEC_AW-1:0] vec_waddr,
  input  logic [7:0]        vec_wdata,
  input  logic [VEC_AW-1:0] vec_raddr,
  output logic [7:0]        vec_rdata,
  output logic              ram_wr_req,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic              ram_wr_ack,
  output logic              mem_pwr_en,
  output logic              lock_o,
  output logic              busy_o,
  output logic [KEY_W-1:0]  key_o
);
  // Named internal events, visible to the bound checker.
  logic tamp_hit;
  logic seq_busy;
  logic wipe_start;
  logic wipe_reload;
  logic lock_arm;
  logic vec_wr_ok;

  logic             lock_q;
  logic [KEY_W-1:0] key_q;
  logic [7:0]       vec_mem [VEC_BYTES];

  tamper_filter #(
    .REJECT_CYC(REJECT_CYC),
    .ACCEPT_CYC(ACCEPT_CYC)
  ) u_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_raw(tamper_pin),
    .hit    (tamp_hit)
  );

  assign wipe_start = !seq_busy && (cmd_lock_clr || tamp_hit);
  assign lock_arm   = !seq_busy && cmd_lock_set && !wipe_start;
  assign vec_wr_ok  = vec_we && !lock_q && !seq_busy && (int'(vec_waddr) < VEC_BYTES);

  wipe_seq #(
    .RAM_DEPTH  (RAM_DEPTH),
    .PWR_OFF_CYC(PWR_OFF_CYC),
    .RAM_AW     (RAM_AW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .kick       (wipe_start),
    .kick_tamper(tamp_hit),
    .ram_wr_ack (ram_wr_ack),
    .busy       (seq_busy),
    .mem_pwr_en (mem_pwr_en),
    .ram_wr_req (ram_wr_req),
    .ram_addr   (ram_addr),
    .reload     (wipe_reload)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      key_q  <= '0;
    end else begin
      if (wipe_start)    lock_q <= 1'b0;
      else if (lock_arm) lock_q <= 1'b1;

      if (wipe_start)       key_q <= '0;
      else if (wipe_reload) key_q <= rng_word;
    end
  end

  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_vec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        vec_mem[g] <= '0;
      else if (wipe_start)
        vec_mem[g] <= '0;
      else if (vec_wr_ok && (vec_waddr == VEC_AW'(g)))
        vec_mem[g] <= vec_wdata;
    end
  end

  assign vec_rdata = (int'(vec_raddr) < VEC_BYTES) ? vec_mem[vec_raddr] : 8'h00;
  assign ld_ok     = ld_req && !lock_q && !seq_busy;
  assign ld_deny   = ld_req && (lock_q || seq_busy);
  assign ram_wdata = 8'h00;
  assign lock_o    = lock_q;
  assign busy_o    = seq_busy;
  assign key_o     = key_q;

endmodule

module seclock_ctrl_chk #(
  parameter int unsigned KEY_W  = 64,
  parameter int unsigned RAM_AW = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_lock_set,
  input logic              cmd_lock_clr,
  input logic              ld_req,
  input logic              ld_ok,
  input logic              ld_deny,
  input logic              ram_wr_req,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              ram_wr_ack,
  input logic              mem_pwr_en,
  input logic              lock_o,
  input logic              busy_o,
  input logic [KEY_W-1:0]  key_o,
  input logic              tamp_hit
);

  p_clear_wipes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && cmd_lock_clr) |=> (busy_o && !lock_o && key_o == '0));

  p_tamper_power_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && tamp_hit) |=> (busy_o && !mem_pwr_en && !ram_wr_req));

  p_power_off_in_cascade_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pwr_en |-> (busy_o && !ram_wr_req));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_req && !ram_wr_ack) |=> (ram_wr_req && $stable(ram_addr)));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr_req && ram_wr_ack) |=>
      (!ram_wr_req || ram_addr == RAM_AW'($past(ram_addr) + 1'b1)));

  p_key_zero_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> key_o == '0);

  p_lock_by_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> ($past(cmd_lock_set) && !$past(busy_o) && !$past(cmd_lock_clr)));

  p_refuse_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_req && (lock_o || busy_o)) |-> (ld_deny && !ld_ok));

endmodule

bind seclock_ctrl seclock_ctrl_chk #(.KEY_W(KEY_W), .RAM_AW(RAM_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_lock_set(cmd_lock_set),
  .cmd_lock_clr(cmd_lock_clr),
  .ld_req      (ld_req),
  .ld_ok       (ld_ok),
  .ld_deny     (ld_deny),
  .ram_wr_req  (ram_wr_req),
  .ram_addr    (ram_addr),
  .ram_wr_ack  (ram_wr_ack),
  .mem_pwr_en  (mem_pwr_en),
  .lock_o      (lock_o),
  .busy_o      (busy_o),
  .key_o       (key_o),
  .tamp_hit    (tamp_hit)
);

// File: tb/seclock_ctrl_tb_top.sv
`timescale 1ns/1ps
module seclock_ctrl_tb_top;
  localparam int unsigned KW    = 64;
  localparam int unsigned VB    = 48;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned REJ   = 4;
  localparam int unsigned ACC   = 12;
  localparam int unsigned POFF  = 5;
  localparam int unsigned VAW   = 6;
  localparam int unsigned RAW   = 4;

  // {address, write data, expected read-back}
  localparam logic [21:0] VTAB [0:6] = '{
    {6'd0,  8'hA5, 8'hA5},
    {6'd1,  8'h3C, 8'h3C},
    {6'd47, 8'h81, 8'h81},
    {6'd48, 8'h77, 8'h00},
    {6'd63, 8'hFF, 8'h00},
    {6'd20, 8'h00, 8'h00},
    {6'd20, 8'h5A, 8'h5A}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmd_lock_set = 1'b0;
  logic           cmd_lock_clr = 1'b0;
  logic           tamper_pin = 1'b0;
  logic [KW-1:0]  rng_word = '0;
  logic           ld_req = 1'b0;
  logic           ld_ok, ld_deny;
  logic           vec_we = 1'b0;
  logic [VAW-1:0] vec_waddr = '0;
  logic [7:0]     vec_wdata = '0;
  logic [VAW-1:0] vec_raddr = '0;
  logic [7:0]     vec_rdata;
  logic           ram_wr_req;
  logic [RAW-1:0] ram_addr;
  logic [7:0]     ram_wdata;
  logic           ram_wr_ack = 1'b0;
  logic           mem_pwr_en, lock_o, busy_o;
  logic [KW-1:0]  key_o;

  int n_total = 0;
  int n_fail  = 0;
  int pwr_low = 0;
  int wr_seen = 0;
  int wr_bad  = 0;

  always #2 clk = ~clk;

  seclock_ctrl #(
    .KEY_W(KW), .VEC_BYTES(VB), .RAM_DEPTH(DEPTH),
    .REJECT_CYC(REJ), .ACCEPT_CYC(ACC), .PWR_OFF_CYC(POFF)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_lock_set(cmd_lock_set), .cmd_lock_clr(cmd_lock_clr),
    .tamper_pin(tamper_pin), .rng_word(rng_word), .ld_req(ld_req), .ld_ok(ld_ok),
    .ld_deny(ld_deny), .vec_we(vec_we), .vec_waddr(vec_waddr), .vec_wdata(vec_wdata),
    .vec_raddr(vec_raddr), .vec_rdata(vec_rdata), .ram_wr_req(ram_wr_req),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_wr_ack(ram_wr_ack),
    .mem_pwr_en(mem_pwr_en), .lock_o(lock_o), .busy_o(busy_o), .key_o(key_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  // Serves the RAM walk, stalling each address one cycle before acknowledging.
  // With poke set, set and clear commands are injected during address 3.
  task automatic serve_wipe(input bit poke);
    bit stall = 1'b1;
    wr_seen = 0;
    wr_bad  = 0;
    for (int c = 0; c < 1000; c++) begin
      @(negedge clk);
      cmd_lock_set = 1'b0;
      cmd_lock_clr = 1'b0;
      if (!busy_o) break;
      if (!mem_pwr_en) pwr_low++;
      if (ram_wr_req) begin
        if (ram_addr != RAW'(wr_seen) || ram_wdata != 8'h00) wr_bad++;
        if (stall) begin
          ram_wr_ack = 1'b0;
          stall = 1'b0;
          if (poke && wr_seen == 3) begin
            cmd_lock_set = 1'b1;
            cmd_lock_clr = 1'b1;
          end
        end else begin
          ram_wr_ack = 1'b1;
          wr_seen++;
          stall = 1'b1;
        end
      end else begin
        ram_wr_ack = 1'b0;
      end
    end
    ram_wr_ack = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!lock_o, "R1 lock", 64'(lock_o), 0);
    check(!busy_o, "R1 busy", 64'(busy_o), 0);
    check(key_o == '0, "R1 key", key_o, 0);
    check(mem_pwr_en, "R1 pwr", 64'(mem_pwr_en), 1);
    check(!ram_wr_req, "R1 req", 64'(ram_wr_req), 0);

    // R10: vector store table walk while unlocked
    for (int i = 0; i < 7; i++) begin
      vec_we = 1'b1;
      vec_waddr = VTAB[i][21:16];
      vec_wdata = VTAB[i][15:8];
      @(negedge clk);
      vec_we = 1'b0;
      vec_raddr = VTAB[i][21:16];
      #0.5;
      check(vec_rdata == VTAB[i][7:0], $sformatf("R10 vec[%0d]", VTAB[i][21:16]),
            64'(vec_rdata), 64'(VTAB[i][7:0]));
    end

    // R9: open state grants access
    ld_req = 1'b1;
    #0.5;
    check(ld_ok && !ld_deny, "R9 grant open", {ld_ok, ld_deny}, 2'b10);

    // R8: set command arms the lock
    cmd_lock_set = 1'b1;
    @(negedge clk);
    cmd_lock_set = 1'b0;
    check(lock_o, "R8 lock set", 64'(lock_o), 1);
    check(!ld_ok && ld_deny, "R9 refuse locked", {ld_ok, ld_deny}, 2'b01);
    ld_req = 1'b0;

    // R10: write while locked is ignored
    vec_we = 1'b1; vec_waddr = 6'd1; vec_wdata = 8'hEE;
    @(negedge clk);
    vec_we = 1'b0; vec_raddr = 6'd1;
    #0.5;
    check(vec_rdata == 8'h3C, "R10 locked write ignored", 64'(vec_rdata), 64'h3C);

    // R3: clear command, same-edge erase
    rng_word = 64'h0123_4567_89AB_CDEF;
    cmd_lock_clr = 1'b1;
    @(negedge clk);
    cmd_lock_clr = 1'b0;
    vec_raddr = 6'd0;
    #0.5;
    check(!lock_o && busy_o, "R3 lock clear busy", {lock_o, busy_o}, 2'b01);
    check(key_o == '0, "R3 key zero", key_o, 0);
    check(vec_rdata == 8'h00, "R3 vector zero", 64'(vec_rdata), 0);
    check(mem_pwr_en, "R4 no power drop on command", 64'(mem_pwr_en), 1);

    // R5, R7: walk with stalls and injected commands
    ld_req = 1'b1;
    #0.5;
    check(ld_deny && !ld_ok, "R9 refuse busy", {ld_ok, ld_deny}, 2'b01);
    ld_req = 1'b0;
    serve_wipe(1'b1);
    check(wr_seen == DEPTH, "R5 write count", 64'(wr_seen), 64'(DEPTH));
    check(wr_bad == 0, "R5 address order", 64'(wr_bad), 0);
    check(!lock_o, "R7 set ignored while busy", 64'(lock_o), 0);
    // R6: key from random source
    check(!busy_o && key_o == 64'h0123_4567_89AB_CDEF, "R6 new key", key_o,
          64'h0123_4567_89AB_CDEF);

    // R2: short tamper run is ignored
    cmd_lock_set = 1'b1;
    @(negedge clk);
    cmd_lock_set = 1'b0;
    tamper_pin = 1'b1;
    repeat (REJ - 1) @(negedge clk);
    tamper_pin = 1'b0;
    repeat (12) @(negedge clk);
    check(lock_o && !busy_o, "R2 short pulse ignored", {lock_o, busy_o}, 2'b10);
    check(key_o == 64'h0123_4567_89AB_CDEF, "R2 key kept", key_o, 64'h0123_4567_89AB_CDEF);

    // R2, R4: long tamper run triggers the cascade with a power drop
    rng_word = 64'hFEED_FACE_CAFE_0042;
    pwr_low = 0;
    tamper_pin = 1'b1;
    for (int c = 0; c < ACC + 4; c++) begin
      @(negedge clk);
      if (busy_o) break;
    end
    if (!mem_pwr_en) pwr_low++;
    check(busy_o, "R2 long pulse accepted", 64'(busy_o), 1);
    check(!lock_o && key_o == '0, "R4 lock and key cleared", key_o, 0);
    tamper_pin = 1'b0;
    serve_wipe(1'b0);
    check(pwr_low == POFF, "R4 power-off window", 64'(pwr_low), 64'(POFF));
    check(wr_seen == DEPTH && wr_bad == 0, "R5 walk after tamper", 64'(wr_seen), 64'(DEPTH));
    check(key_o == 64'hFEED_FACE_CAFE_0042, "R6 key after tamper", key_o,
          64'hFEED_FACE_CAFE_0042);

    summary();
  end

endmodule